// File: doc/BRIEF.md
# Radio interrupt status register

This block is the status byte of a packet radio core that a host drives over SPI. It keeps three sticky interrupt flags: receive data ready, transmit done, and retransmit limit reached. The host clears each flag by writing a one to its bit. The byte also shows the pipe number of the packet at the head of a small receive tag queue, and a flag that is set when the transmit queue is full. The link engine reports events as single-cycle pulses. The receive and transmit queues report their pushes and pops as strobes. The host writes the register through a simple write port.

Every SPI command starts with a falling chip select. At that point the current status byte is captured and shifted out on MISO, most significant bit first, while the command byte arrives. A no-operation command therefore reads the status. The receive queue stores only 3-bit pipe tags; the payload memory sits elsewhere. A pending retransmit-limit flag blocks further transmissions until the host clears it.

Top module: `radio_status`

## Requirements
- R1: The status byte is {0, rx_ready, tx_done, retx_limit, pipe[2:0], tx_full}, with rx_ready at bit 6, tx_done at bit 5, retx_limit at bit 4, the pipe field at bits 3:1 and tx_full at bit 0. Bit 7 always reads 0, and writing 1 to it has no effect.
- R2: After reset the status byte is 8'h0E, MISO is 0 and tx_permit is 1.
- R3: When a register write carries a 1 in bit 6, 5 or 4, that flag clears. A 0 leaves the flag unchanged. Writes never change bits 7, 3:1 or 0.
- R4: If a set event and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R5: rx_ready is set in the same cycle as any accepted receive push. A push is dropped, and rx_ready is not set, when the queue already holds 3 tags or when the pushed tag is above 5.
- R6: The pipe field shows the tag at the head of the receive queue, or 7 when the queue is empty. Each pop advances the field to the next tag, and it never shows 6. A pop on an empty queue is ignored.
- R7: With auto_ack_en at 1, tx_done is set by ev_ack_rcvd. With auto_ack_en at 0, ev_tx_sent sets it instead.
- R8: If the retransmit-limit event and a transmit-done event arrive in the same cycle, only retx_limit is set. rx_ready and tx_done may be set together.
- R9: While retx_limit is 1, tx_permit is 0 and transmit pops are ignored.
- R10: tx_full is 1 exactly when the transmit occupancy count (0 to 3) equals 3. A push at 3 is dropped, and a pop at 0 is ignored.
- R11: On a falling spi_csn the current status byte is captured. MISO then shows its MSB, and after each falling edge of spi_sclk it shows the next bit. Zeros follow the eighth bit. MISO is 0 while spi_csn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; SPI pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | A received packet enters the receive queue |
| rx_push_pipe | input | 3 | Pipe tag of the pushed packet |
| rx_pop | input | 1 | Payload read removes the head packet |
| tx_push | input | 1 | A packet is loaded into the transmit queue |
| tx_pop | input | 1 | A transmission takes the next packet |
| auto_ack_en | input | 1 | Auto-acknowledge mode for the tx_done source |
| ev_tx_sent | input | 1 | Pulse: packet left the transmitter |
| ev_ack_rcvd | input | 1 | Pulse: acknowledgement received |
| ev_retx_limit | input | 1 | Pulse: retransmit count exhausted |
| reg_wr_en | input | 1 | Status register write strobe |
| reg_wr_data | input | 8 | Write data; bits 6:4 are write-one-to-clear |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI serial clock |
| spi_miso | output | 1 | Serial status output |
| status_byte | output | 8 | Parallel status byte |
| tx_permit | output | 1 | A new transmission may start |

## Verification
The assertions check on every cycle the properties that concern a single flag or queue. A set beats a clear on the same flag. A one in the write data clears a flag that has no set event pending. The queue occupancy never goes past its depth. A push is dropped when the queue is full, and an empty queue stays empty when popped. A held transmit count stays put. The shift register loads and shifts as expected, the pipe field never reads 6, and transmit done never rises right after a retransmit-limit event. The bench's scenarios cover what depends on ordering: which tag the field shows after a series of pushes and pops, which event sets tx_done in each acknowledge mode, that one status byte is read correctly over SPI, and that a cleared retransmit limit lets transmit pops through again. A behavioural model runs alongside and compares the byte, MISO and tx_permit on every clock.

// File: rtl/radio_stat_pkg.sv
package radio_stat_pkg;
  localparam int TAG_W = 3;
  localparam logic [TAG_W-1:0] PIPE_EMPTY = 3'b111;
  localparam logic [TAG_W-1:0] PIPE_LAST = 3'd5;
  localparam int NFLAG = 3;

  typedef struct packed {
    logic             rsvd;
    logic             rx_ready;
    logic             tx_done;
    logic             retx_limit;
    logic [TAG_W-1:0] pipe;
    logic             tx_full;
  } stat_t;

  function automatic logic tag_legal(input logic [TAG_W-1:0] tag);
    return tag <= PIPE_LAST;
  endfunction

  function automatic logic [TAG_W-1:0] pipe_field(input logic empty,
                                                  input logic [TAG_W-1:0] head);
    return empty ? PIPE_EMPTY : head;
  endfunction

  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/irq_flags.sv
module irq_flags
  import radio_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_evt,
  input  logic [NFLAG-1:0] clr_mask,
  output logic [NFLAG-1:0] flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flag_next(flags[i], set_evt[i], clr_mask[i]);
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flags[i]);
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && !set_evt[i]) |=> !flags[i]);
    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_mask[i] && !set_evt[i]) |=> $stable(flags[i]));
  end
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import radio_stat_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             pop,
  output logic             push_ok,
  output logic [TAG_W-1:0] head_tag,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             pop_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign push_ok  = push & tag_legal(push_tag) & ~full;
  assign pop_ok   = pop & ~empty;
  assign head_tag = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_drop_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(head_tag)));
  p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);
  p_head_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> tag_legal(head_tag));
endmodule

// File: rtl/tx_occ_counter.sv
module tx_occ_counter #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  logic hold,
  output logic full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~hold & (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + CW'(push_ok) - CW'(pop_ok);
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !push) |=> $stable(count));
  p_full_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/status_shifter.sv
module status_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         csn,
  input  logic         sclk,
  input  logic [W-1:0] par_in,
  output logic         miso
);
  logic         csn_q, sclk_q;
  logic [W-1:0] shreg;
  logic         load, shift;

  assign load  = csn_q & ~csn;
  assign shift = ~csn & sclk_q & ~sclk & ~load;
  assign miso  = ~csn & shreg[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q  <= 1'b1;
      sclk_q <= 1'b0;
      shreg  <= '0;
    end else begin
      csn_q  <= csn;
      sclk_q <= sclk;
      if (load)       shreg <= par_in;
      else if (shift) shreg <= {shreg[W-2:0], 1'b0};
    end
  end

  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (shreg == $past(par_in)));
  p_shift_r11: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> (shreg == {$past(shreg[W-2:0]), 1'b0}));
endmodule

// File: rtl/radio_status.sv
module radio_status
  import radio_stat_pkg::*;
#(
  parameter int RX_DEPTH = 3,
  parameter int TX_DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_push,
  input  logic [2:0] rx_push_pipe,
  input  logic       rx_pop,
  input  logic       tx_push,
  input  logic       tx_pop,
  input  logic       auto_ack_en,
  input  logic       ev_tx_sent,
  input  logic       ev_ack_rcvd,
  input  logic       ev_retx_limit,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wr_data,
  input  logic       spi_csn,
  input  logic       spi_sclk,
  output logic       spi_miso,
  output logic [7:0] status_byte,
  output logic       tx_permit
);
  // named internal events for the assertions
  logic             rx_push_ok;
  logic             txd_evt;
  logic             txd_set;
  logic [NFLAG-1:0] set_evt, clr_mask, flags;
  logic [TAG_W-1:0] rx_head;
  logic             rx_empty, rx_full, tx_full;
  stat_t            stat;

  assign txd_evt  = auto_ack_en ? ev_ack_rcvd : ev_tx_sent;
  assign txd_set  = txd_evt & ~ev_retx_limit;
  // flag index 2: rx_ready, 1: tx_done, 0: retx_limit (bits 6:4)
  assign set_evt  = {rx_push_ok, txd_set, ev_retx_limit};
  assign clr_mask = reg_wr_en ? reg_wr_data[6:4] : '0;

  irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_mask(clr_mask), .flags(flags)
  );

  rx_tag_fifo #(.DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_tag(rx_push_pipe), .pop(rx_pop),
    .push_ok(rx_push_ok), .head_tag(rx_head), .empty(rx_empty), .full(rx_full)
  );

  tx_occ_counter #(.DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop), .hold(flags[0]), .full(tx_full)
  );

  always_comb begin
    stat.rsvd       = 1'b0;
    stat.rx_ready   = flags[2];
    stat.tx_done    = flags[1];
    stat.retx_limit = flags[0];
    stat.pipe       = pipe_field(rx_empty, rx_head);
    stat.tx_full    = tx_full;
  end

  assign status_byte = stat;
  assign tx_permit   = ~flags[0];

  status_shifter #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .csn(spi_csn), .sclk(spi_sclk),
    .par_in(status_byte), .miso(spi_miso)
  );

  p_pipe_never6_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[3:1] != 3'd6);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !status_byte[7]);
  p_retx_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retx_limit |=> !$rose(status_byte[5]));
  p_full_push_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_push && !status_byte[6] && !(reg_wr_en && reg_wr_data[6])) |=> !status_byte[6]);
endmodule

// File: tb/tb_radio_status.sv
module tb_radio_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
  logic [2:0] rx_push_pipe = 0;
  logic auto_ack_en = 0, ev_tx_sent = 0, ev_ack_rcvd = 0, ev_retx_limit = 0;
  logic reg_wr_en = 0;
  logic [7:0] reg_wr_data = 0;
  logic spi_csn = 1, spi_sclk = 0;
  logic spi_miso, tx_permit;
  logic [7:0] status_byte;

  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  radio_status dut (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_push_pipe(rx_push_pipe),
    .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop), .auto_ack_en(auto_ack_en),
    .ev_tx_sent(ev_tx_sent), .ev_ack_rcvd(ev_ack_rcvd), .ev_retx_limit(ev_retx_limit),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .spi_csn(spi_csn),
    .spi_sclk(spi_sclk), .spi_miso(spi_miso), .status_byte(status_byte),
    .tx_permit(tx_permit)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int   m_q[$];
  int   m_txc = 0;
  bit   m_rx = 0, m_td = 0, m_rl = 0;
  bit   m_csn_p = 1, m_sclk_p = 0;
  logic [7:0] m_sh = 0;

  function automatic logic [7:0] m_stat();
    int p;
    p = (m_q.size() == 0) ? 7 : m_q[0];
    return {1'b0, m_rx, m_td, m_rl, 3'(p), (m_txc == 3)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_txc = 0; m_rx = 0; m_td = 0; m_rl = 0;
      m_csn_p = 1; m_sclk_p = 0; m_sh = 0;
    end else begin
      bit push_ok, pop_ok, tpush, tpop, tds, rls;
      logic [7:0] old;
      old = m_stat();
      if (m_csn_p && !spi_csn) m_sh = old;
      else if (!spi_csn && m_sclk_p && !spi_sclk) m_sh = {m_sh[6:0], 1'b0};
      m_csn_p = spi_csn; m_sclk_p = spi_sclk;
      push_ok = rx_push && rx_push_pipe <= 5 && m_q.size() < 3;
      pop_ok  = rx_pop && m_q.size() > 0;
      tpush   = tx_push && m_txc < 3;
      tpop    = tx_pop && !m_rl && m_txc > 0;
      rls     = ev_retx_limit;
      tds     = (auto_ack_en ? ev_ack_rcvd : ev_tx_sent) && !rls;
      m_rx = push_ok | (m_rx & !(reg_wr_en && reg_wr_data[6]));
      m_td = tds     | (m_td & !(reg_wr_en && reg_wr_data[5]));
      m_rl = rls     | (m_rl & !(reg_wr_en && reg_wr_data[4]));
      if (pop_ok) void'(m_q.pop_front());
      if (push_ok) m_q.push_back(int'(rx_push_pipe));
      m_txc = m_txc + int'(tpush) - int'(tpop);
    end
    #2;
    begin
      logic [7:0] e;
      e = m_stat();
      chk("R1 reserved bit", status_byte[7], 0);
      chk("R5 rx_ready", status_byte[6], e[6]);
      chk("R7 tx_done", status_byte[5], e[5]);
      chk("R8 retx_limit", status_byte[4], e[4]);
      chk("R6 pipe field", status_byte[3:1], e[3:1]);
      chk("R10 tx_full", status_byte[0], e[0]);
      chk("R9 tx_permit", tx_permit, !m_rl);
      chk("R11 miso", spi_miso, spi_csn ? 0 : m_sh[7]);
    end
  end

  task automatic step();
    @(negedge clk);
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    ev_tx_sent = 0; ev_ack_rcvd = 0; ev_retx_limit = 0; reg_wr_en = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_en = 1; reg_wr_data = d; step();
  endtask

  task automatic rpush(input logic [2:0] t);
    rx_push = 1; rx_push_pipe = t; step();
  endtask

  initial begin
    #1_000_000;
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R2 reset status", status_byte, 8'h0E);
    chk("R2 reset miso", spi_miso, 0);
    chk("R2 reset permit", tx_permit, 1);

    rpush(3'd2);  chk("R5 push sets rx_ready", status_byte, 8'h44);
    wr(8'h40);    chk("R3 w1c rx_ready", status_byte, 8'h04);
    wr(8'h80);    chk("R1 bit7 write ignored", status_byte, 8'h04);
    wr(8'h0F);    chk("R3 read-only bits unchanged", status_byte, 8'h04);
    rpush(3'd6);  chk("R5 tag 6 dropped", status_byte, 8'h04);
    rpush(3'd4);
    rpush(3'd5);  chk("R6 head stays pipe 2", status_byte, 8'h44);
    wr(8'h40);
    rpush(3'd1);  chk("R5 push to full queue dropped", status_byte, 8'h04);
    rx_pop = 1; step(); chk("R6 pop to pipe 4", status_byte, 8'h08);
    rx_pop = 1; step(); chk("R6 pop to pipe 5", status_byte, 8'h0A);
    rx_pop = 1; step(); chk("R6 empty shows 7", status_byte, 8'h0E);
    rx_pop = 1; step(); chk("R6 pop on empty ignored", status_byte, 8'h0E);

    reg_wr_en = 1; reg_wr_data = 8'h40; rpush(3'd3);
    chk("R4 set wins over clear", status_byte, 8'h46);
    rx_pop = 1; wr(8'h40); chk("R6 R3 pop and clear", status_byte, 8'h0E);

    auto_ack_en = 1;
    ev_tx_sent = 1; step(); chk("R7 sent ignored with auto ack", status_byte, 8'h0E);
    ev_ack_rcvd = 1; step(); chk("R7 ack sets tx_done", status_byte, 8'h2E);
    wr(8'h20);
    auto_ack_en = 0;
    ev_ack_rcvd = 1; step(); chk("R7 ack ignored without auto ack", status_byte, 8'h0E);
    ev_tx_sent = 1; step(); chk("R7 sent sets tx_done", status_byte, 8'h2E);
    wr(8'h20);

    auto_ack_en = 1;
    ev_ack_rcvd = 1; rpush(3'd0); chk("R8 rx_ready with tx_done", status_byte, 8'h60);
    wr(8'h60);    chk("R3 both cleared, pipe 0", status_byte, 8'h00);
    rx_pop = 1; step();
    ev_ack_rcvd = 1; ev_retx_limit = 1; step();
    chk("R8 retx wins", status_byte, 8'h1E);
    chk("R9 permit low", tx_permit, 0);

    spi_csn = 0; step(); step();
    got = 0;
    for (int i = 0; i < 8; i++) begin
      got = {got[6:0], spi_miso};
      spi_sclk = 1; step(); step();
      spi_sclk = 0; step(); step();
    end
    chk("R11 status byte over SPI", got, 8'h1E);
    chk("R11 zeros after byte", spi_miso, 0);
    spi_csn = 1; step();
    chk("R11 miso idle", spi_miso, 0);

    tx_push = 1; step(); tx_push = 1; step(); tx_push = 1; step();
    chk("R10 tx_full at 3", status_byte, 8'h1F);
    tx_pop = 1; step(); chk("R9 pop held off", status_byte, 8'h1F);
    wr(8'h10);    chk("R9 cleared retx", status_byte, 8'h0F);
    chk("R9 permit back", tx_permit, 1);
    tx_push = 1; step(); chk("R10 push at 3 dropped", status_byte, 8'h0F);
    tx_pop = 1; step(); chk("R10 pop clears full", status_byte, 8'h0E);

    for (int n = 0; n < 4000; n++) begin
      rx_push = ($urandom_range(0, 3) == 0);
      rx_push_pipe = 3'($urandom_range(0, 7));
      rx_pop = ($urandom_range(0, 3) == 0);
      tx_push = ($urandom_range(0, 2) == 0);
      tx_pop = ($urandom_range(0, 2) == 0);
      auto_ack_en = ($urandom_range(0, 15) == 0) ? ~auto_ack_en : auto_ack_en;
      ev_tx_sent = ($urandom_range(0, 7) == 0);
      ev_ack_rcvd = ($urandom_range(0, 7) == 0);
      ev_retx_limit = ($urandom_range(0, 15) == 0);
      reg_wr_en = ($urandom_range(0, 5) == 0);
      reg_wr_data = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 9) == 0) spi_csn = ~spi_csn;
      if ($urandom_range(0, 2) == 0) spi_sclk = ~spi_sclk;
      step();
    end

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule